// File: doc/BRIEF.md
# Bitline Precharge and Sense Sequencer

This controller drives the access phases of a single SRAM bank. A one-cycle start request carries a read/write flag and a row address. The controller then steps through a fixed series of phases, each lasting a number of clock cycles set by a parameter, and raises the matching control lines for the bitlines, the row, the sense path and the write path.

A read first charges both bitlines of every column high and levels them against each other. The selected row line is then opened so that the cell can pull one bitline of its pair down. After a programmed number of cycles, enough swing has built up, and the controller fires the sense clock while it cuts the bitlines off from the sense amplifier. A write drives the complementary data onto the pairs first and opens the row line only after that. Each access ends with a single-cycle completion pulse.

The controller holds the row address at the start of an access. It reports busy from the cycle after the request until the completion pulse, and it discards any request that arrives while it is busy. Only the sequencing is modelled. The analog behaviour of the cells is out of scope.

Top module: `bl_seq_ctrl`

## Requirements
- R1: A read drives `prech` high for exactly PRE_CYC cycles, starting in the first cycle after the accepted start, and no row line is active in those cycles.
- R2: On a read, the row line rises in the cycle right after the last `prech` cycle and stays high for SWING_CYC cycles.
- R3: On a read, `sense_clk` rises exactly SWING_CYC cycles after the row line rises, and stays high for SENSE_CYC cycles.
- R4: `iso` is high in exactly the cycles where `sense_clk` is high.
- R5: A write holds `wdrv` high for DRV_CYC cycles with no row line active, then holds both `wdrv` and the row line high for WR_CYC more cycles. `prech` and `sense_clk` stay low during a write.
- R6: `wl` has at most one bit set. While a row is open, the set bit is bit number `row`, taken from the row value present when start was accepted.
- R7: `prech` and any `wl` bit are never high in the same cycle, and `wdrv` and `sense_clk` are never high in the same cycle.
- R8: In the cycle after the last active phase, `done` is high for exactly one cycle, with every row line already low. On a read this is cycle PRE_CYC+SWING_CYC+SENSE_CYC counted from 0; on a write it is cycle DRV_CYC+WR_CYC. `busy` is high from cycle 0 through the `done` cycle.
- R9: A start request while `busy` is high is ignored. It neither changes the open row nor adds an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Access request, sampled while idle |
| wr | input | 1 | 1 = write, 0 = read |
| row | input | ROW_BITS | Row address |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| prech | output | 1 | Bitline precharge and equalize |
| wl | output | 2**ROW_BITS | One-hot row line vector |
| sense_clk | output | 1 | Sense amplifier clock |
| iso | output | 1 | Bitline isolation from the sense amplifier |
| wdrv | output | 1 | Write driver enable |

## Verification
The assertions assume that `row` and `wr` are stable in the cycle when start is sampled, and that every phase parameter is at least one. The stimulus changes these inputs only on the falling edge and never alters the parameters. The row check assumes the row of the accepted request is the one that must appear. To test this, the bench sends extra requests with a different row while busy, and drops them before the completion pulse so that none of them could be accepted legally.

// File: rtl/bl_seq_ctrl.sv
module bl_seq_ctrl #(
  parameter int ROW_BITS  = 4,
  parameter int PRE_CYC   = 2,
  parameter int SWING_CYC = 3,
  parameter int SENSE_CYC = 2,
  parameter int DRV_CYC   = 2,
  parameter int WR_CYC    = 2,
  parameter int CNT_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     wr,
  input  logic [ROW_BITS-1:0]      row,
  output logic                     busy,
  output logic                     done,
  output logic                     prech,
  output logic [(1<<ROW_BITS)-1:0] wl,
  output logic                     sense_clk,
  output logic                     iso,
  output logic                     wdrv
);
  localparam int ROWS = 1 << ROW_BITS;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_RISE, S_SENSE, S_DRIVE, S_WRITE, S_FIN} st_t;

  st_t                 st, st_nx;
  logic [CNT_W-1:0]    cnt, len;
  logic [ROW_BITS-1:0] row_q;
  logic                last, wl_on;

  always_comb begin
    case (st)
      S_PRE:   len = CNT_W'(PRE_CYC);
      S_RISE:  len = CNT_W'(SWING_CYC);
      S_SENSE: len = CNT_W'(SENSE_CYC);
      S_DRIVE: len = CNT_W'(DRV_CYC);
      S_WRITE: len = CNT_W'(WR_CYC);
      default: len = CNT_W'(1);
    endcase
  end

  assign last = (cnt == len - CNT_W'(1));

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (start) st_nx = wr ? S_DRIVE : S_PRE;
      S_PRE:   if (last) st_nx = S_RISE;
      S_RISE:  if (last) st_nx = S_SENSE;
      S_SENSE: if (last) st_nx = S_FIN;
      S_DRIVE: if (last) st_nx = S_WRITE;
      S_WRITE: if (last) st_nx = S_FIN;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      row_q <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st) cnt <= '0;
      else if (st != S_IDLE) cnt <= cnt + CNT_W'(1);
      if (st == S_IDLE && start) row_q <= row;
    end
  end

  assign wl_on     = (st == S_RISE) || (st == S_WRITE);
  assign wl        = wl_on ? (ROWS'(1) << row_q) : '0;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign prech     = (st == S_PRE);
  assign sense_clk = (st == S_SENSE);
  assign iso       = (st == S_SENSE);
  assign wdrv      = (st == S_DRIVE) || (st == S_WRITE);
endmodule

// File: rtl/bl_seq_ctrl_chk.sv
module bl_seq_ctrl_chk #(
  parameter int ROWS      = 16,
  parameter int SWING_CYC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            prech,
  input logic [ROWS-1:0] wl,
  input logic            sense_clk,
  input logic            iso,
  input logic            wdrv
);
  logic [15:0] wl_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wl_age <= '0;
    else if (|wl) wl_age <= wl_age + 16'd1;
    else wl_age <= '0;
  end

  // R7
  no_pre_wl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(prech && |wl));
  // R7
  no_drv_sense_chk: assert property (@(posedge clk) disable iff (!rst_n) !(wdrv && sense_clk));
  // R6
  wl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wl));
  // R6
  wl_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wl && $past(|wl)) |-> (wl == $past(wl)));
  // R4
  iso_with_sense_chk: assert property (@(posedge clk) disable iff (!rst_n) sense_clk == iso);
  // R2
  wl_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(prech) |-> |wl);
  // R3
  sense_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense_clk) |-> (wl_age == 16'(SWING_CYC)));
  // R5
  drive_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|wl) && wdrv) |-> $past(wdrv));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_wl_low_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (wl == '0));
endmodule

bind bl_seq_ctrl bl_seq_ctrl_chk #(.ROWS(ROWS), .SWING_CYC(SWING_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .prech(prech), .wl(wl),
  .sense_clk(sense_clk), .iso(iso), .wdrv(wdrv)
);

// File: tb/test_bl_seq_ctrl.sv
`timescale 1ns/1ps
module test_bl_seq_ctrl;
  localparam int RB = 4, NR = 1 << RB;
  localparam int PRE = 2, SW = 3, SE = 2, DRV = 2, WRC = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr = 1'b0;
  logic [RB-1:0] row = '0;
  logic busy, done, prech, sense_clk, iso, wdrv;
  logic [NR-1:0] wl;

  always #2.5 clk = ~clk;

  bl_seq_ctrl #(.ROW_BITS(RB), .PRE_CYC(PRE), .SWING_CYC(SW), .SENSE_CYC(SE),
                .DRV_CYC(DRV), .WR_CYC(WRC)) i_bl_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .row(row), .busy(busy),
    .done(done), .prech(prech), .wl(wl), .sense_clk(sense_clk), .iso(iso), .wdrv(wdrv));

  typedef struct packed { logic w; logic [RB-1:0] r; } exp_t;
  exp_t q[$];
  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: 0 prech, 1 wl, 2 sense, 3 iso, 4 wdrv
  int first[5], lastc[5], cnt[5];
  int cyc = 0, badrow = 0;
  logic busy_d = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        logic [4:0] s;
        if (!busy_d) begin
          cyc = 0; badrow = 0;
          for (int k = 0; k < 5; k++) begin first[k] = -1; lastc[k] = -1; cnt[k] = 0; end
        end
        s = {wdrv, iso, sense_clk, |wl, prech};
        for (int k = 0; k < 5; k++)
          if (s[k]) begin
            if (cnt[k] == 0) first[k] = cyc;
            lastc[k] = cyc;
            cnt[k]++;
          end
        if (|wl && q.size() > 0 && wl != (NR'(1) << q[0].r)) badrow++;
        if (done) begin
          if (q.size() == 0) chk("R9 unexpected access", 1, 0);
          else begin
            exp_t e;
            e = q.pop_front();
            chk("R6 row line", badrow, 0);
            chk("R7 wl during done", int'(|wl), 0);
            if (!e.w) begin
              chk("R1 prech first", first[0], 0);
              chk("R1 prech last", lastc[0], PRE - 1);
              chk("R2 wl first", first[1], PRE);
              chk("R2 wl last", lastc[1], PRE + SW - 1);
              chk("R3 sense first", first[2], PRE + SW);
              chk("R3 sense count", cnt[2], SE);
              chk("R4 iso first", first[3], first[2]);
              chk("R4 iso count", cnt[3], SE);
              chk("R7 wdrv in read", cnt[4], 0);
              chk("R8 read done cycle", cyc, PRE + SW + SE);
            end else begin
              chk("R5 wdrv first", first[4], 0);
              chk("R5 wdrv last", lastc[4], DRV + WRC - 1);
              chk("R5 wl first", first[1], DRV);
              chk("R5 wl last", lastc[1], DRV + WRC - 1);
              chk("R5 prech in write", cnt[0], 0);
              chk("R7 sense in write", cnt[2], 0);
              chk("R8 write done cycle", cyc, DRV + WRC);
            end
          end
        end
        cyc++;
      end else if (done) chk("R8 done while idle", 1, 0);
      busy_d = busy;
    end
  end

  task automatic access(input logic w, input int r, input bit poke);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; wr = w; row = RB'(r);
    q.push_back('{w: w, r: RB'(r)});
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R9: requests while busy must be dropped
      start = 1'b1; wr = ~w; row = RB'(r + 7);
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", int'(busy), 0);
    chk("R7 reset outputs", int'({prech, |wl, sense_clk, iso, wdrv, done}), 0);
    rst_n = 1'b1;
    access(1'b0, 0, 0);
    access(1'b0, NR - 1, 0);
    access(1'b1, 3, 0);
    access(1'b1, 0, 1);
    access(1'b0, 5, 1);
    access(1'b1, NR - 1, 0);
    access(1'b0, 9, 0);
    access(1'b0, 10, 1);
    access(1'b1, 6, 1);
    repeat (10) @(negedge clk);
    chk("R9 pending accesses", q.size(), 0);
    chk("R9 idle at end", int'(busy), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk("watchdog", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule